// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Circular Pointers

This block is the arithmetic core of a control-loop filter. Each strobe takes a pair of signed Q15 operands. It forms their Q31 product and adds that product into a wide accumulator. The accumulator has four guard bits above the 32-bit product, so long sums of products can grow without wrapping. A sticky flag reports when a sum leaves the 36-bit signed range anyway.

Next to the arithmetic sit two address pointers, one for filter coefficients and one for data samples. Each strobe advances both pointers. Only the low bits selected by a power-of-two size mask take part in the increment, so each pointer runs around a circular buffer of 2 to 256 entries and the upper bits stay fixed. A finite impulse response loop therefore runs with no software wrap checks.

The caller seeds the accumulator by clearing it or loading it, and seeds the pointers with base addresses.

Top module: `frac_mac_modulo`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `acc` is 0, `ovf` is 0 and both pointers are 0.
- R2: The product is the signed 16x16 product of `op_a` and `op_b` shifted left by one bit (Q31). It is sign-extended to 36 bits and appears in `acc` one cycle after the `mac_en` strobe.
- R3: When both operands are 0x8000, the product is 0x7FFFFFFF instead of +1.0.
- R4: Successive strobes sum their products. In a cycle with none of `mac_en`, `clr` and `ld` asserted, `acc` holds its value.
- R5: When `clr` is asserted together with `mac_en`, the new `acc` is the product alone. When `clr` is asserted alone, `acc` becomes 0.
- R6: When `ld` is asserted, `acc` takes `ld_val`. `ld` overrides `mac_en` and `clr` for the accumulator.
- R7: `ovf` sets when an accumulate result leaves the 36-bit signed range, and it stays set until `ovf_clr` is asserted. A new overflow in the same cycle as `ovf_clr` keeps the flag set. The stored sum wraps modulo 2^36.
- R8: On each `mac_en`, each pointer becomes (p & ~mask) | ((p+1) & mask), where mask is `size_mask` zero-extended. Bits above the mask never change, and the masked field wraps from all-ones to zero.
- R9: `ptr_ld` loads `coef_base` and `samp_base` into the pointers. It takes priority over the increment.
- R10: Any mask of the form 2^k-1, for k from 1 to 8, gives a buffer of 2^k entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_en | input | 1 | Multiply-accumulate strobe, also advances the pointers |
| clr | input | 1 | Zero the accumulator base |
| ld | input | 1 | Load the accumulator from `ld_val` |
| ld_val | input | 36 | Accumulator load value |
| ovf_clr | input | 1 | Clear the overflow flag |
| op_a | input | 16 | Q15 operand (coefficient) |
| op_b | input | 16 | Q15 operand (sample) |
| size_mask | input | 8 | Circular buffer mask, 2^k-1 |
| ptr_ld | input | 1 | Load the pointer bases |
| coef_base | input | 16 | Coefficient pointer load value |
| samp_base | input | 16 | Sample pointer load value |
| coef_ptr | output | 16 | Coefficient pointer |
| samp_ptr | output | 16 | Sample pointer |
| acc | output | 36 | Accumulator |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Every result is one register away from its cause. The accumulator, the flag and both pointers reflect a strobe, clear, load or pointer load on the first rising edge after it. The bench drives each control just after a falling edge and deasserts it at the next falling edge. It compares outputs at that same falling edge, half a cycle after the updating edge. Hold behaviour is checked by waiting one or more further idle cycles and comparing again.

// File: rtl/frac_mac_modulo.sv
module frac_mac_modulo #(
  parameter int DW = 16,
  parameter int GW = 4,
  parameter int AW = 16,
  parameter int MW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_en,
  input  logic              clr,
  input  logic              ld,
  input  logic [2*DW+GW-1:0] ld_val,
  input  logic              ovf_clr,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_b,
  input  logic [MW-1:0]     size_mask,
  input  logic              ptr_ld,
  input  logic [AW-1:0]     coef_base,
  input  logic [AW-1:0]     samp_base,
  output logic [AW-1:0]     coef_ptr,
  output logic [AW-1:0]     samp_ptr,
  output logic [2*DW+GW-1:0] acc,
  output logic              ovf
);
  localparam int PW  = 2*DW;
  localparam int ACW = PW + GW;
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [PW-1:0] raw;
  logic [PW-1:0]  prod;
  logic [ACW-1:0] base;
  logic [ACW:0]   sum;
  logic           sum_ovf;
  logic [AW-1:0]  mask;

  assign raw     = $signed(op_a) * $signed(op_b);
  assign prod    = (op_a == MINV && op_b == MINV) ? {1'b0, {(PW-1){1'b1}}}
                                                  : {raw[PW-2:0], 1'b0};
  assign base    = clr ? '0 : acc;
  assign sum     = {base[ACW-1], base} + {{(GW+1){prod[PW-1]}}, prod};
  assign sum_ovf = sum[ACW] ^ sum[ACW-1];
  assign mask    = {{(AW-MW){1'b0}}, size_mask};

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [AW-1:0] m);
    return (p & ~m) | ((p + 1'b1) & m);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      ovf <= 1'b0;
    end else begin
      if (ld)          acc <= ld_val;
      else if (mac_en) acc <= sum[ACW-1:0];
      else if (clr)    acc <= '0;
      if (mac_en && !ld && sum_ovf) ovf <= 1'b1;
      else if (ovf_clr)             ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_ptr <= '0;
      samp_ptr <= '0;
    end else if (ptr_ld) begin
      coef_ptr <= coef_base;
      samp_ptr <= samp_base;
    end else if (mac_en) begin
      coef_ptr <= step(coef_ptr, mask);
      samp_ptr <= step(samp_ptr, mask);
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) !rst_n |=> (acc == '0 && !ovf && coef_ptr == '0 && samp_ptr == '0));
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n) (!mac_en && !clr && !ld) |=> $stable(acc));
  a_r5_clear_alone: assert property (@(posedge clk) disable iff (!rst_n) (clr && !mac_en && !ld) |=> acc == '0);
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n) ld |=> acc == $past(ld_val));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n) (ovf && !ovf_clr) |=> ovf);
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !ptr_ld) |=> ((coef_ptr & ~$past(mask)) == ($past(coef_ptr) & ~$past(mask))
                          && (samp_ptr & ~$past(mask)) == ($past(samp_ptr) & ~$past(mask))));
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !ptr_ld && (coef_ptr & mask) == mask) |=> (coef_ptr & $past(mask)) == '0);
  a_r9_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> (coef_ptr == $past(coef_base) && samp_ptr == $past(samp_base)));
endmodule

// File: tb/frac_mac_modulo_tb.sv
module frac_mac_modulo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mac_en = 0, clr = 0, ld = 0, ovf_clr = 0, ptr_ld = 0;
  logic [35:0] ld_val = '0;
  logic [15:0] op_a = '0, op_b = '0, coef_base = '0, samp_base = '0;
  logic [7:0]  size_mask = 8'h07;
  logic [15:0] coef_ptr, samp_ptr;
  logic [35:0] acc;
  logic        ovf;
  int n_chk = 0, n_bad = 0;
  logic [35:0] e_acc;

  always #4 clk = ~clk;

  frac_mac_modulo dut_i (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .clr(clr), .ld(ld), .ld_val(ld_val),
    .ovf_clr(ovf_clr), .op_a(op_a), .op_b(op_b), .size_mask(size_mask), .ptr_ld(ptr_ld),
    .coef_base(coef_base), .samp_base(samp_base), .coef_ptr(coef_ptr), .samp_ptr(samp_ptr),
    .acc(acc), .ovf(ovf));

  function automatic logic [35:0] q31(input logic [15:0] a, input logic [15:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b)) * 2;
    if (p == 64'sd2147483648) p = 64'sd2147483647;
    return p[35:0];
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] p, input logic [7:0] m);
    logic [15:0] mm;
    mm = {8'h00, m};
    return (p & ~mm) | ((p + 16'd1) & mm);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
    mac_en = 0; clr = 0; ld = 0; ovf_clr = 0; ptr_ld = 0;
  endtask

  task automatic mac(input logic [15:0] a, input logic [15:0] b);
    op_a = a; op_b = b; mac_en = 1;
    e_acc = e_acc + q31(a, b);
    cyc();
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 acc", acc, 0); chk("R1 ovf", ovf, 0);
    chk("R1 coef_ptr", coef_ptr, 0); chk("R1 samp_ptr", samp_ptr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 acc after release", acc, 0);
    e_acc = '0;
  endtask

  task automatic t_products;
    ld = 1; ld_val = '0; e_acc = '0; cyc();
    op_a = 16'h4000; op_b = 16'h2000; mac_en = 1; clr = 1;
    e_acc = q31(16'h4000, 16'h2000); cyc();
    chk("R2 0.5*0.25", acc, 36'h0_1000_0000);
    op_a = 16'hC000; op_b = 16'h4000; mac_en = 1; clr = 1;
    e_acc = q31(16'hC000, 16'h4000); cyc();
    chk("R2 negative product sign-extended", acc, 36'hF_E000_0000);
  endtask

  task automatic t_minmin;
    clr = 1; op_a = 16'h8000; op_b = 16'h8000; mac_en = 1; cyc();
    chk("R3 -1*-1 saturates", acc, 36'h0_7FFF_FFFF);
    e_acc = 36'h0_7FFF_FFFF;
  endtask

  task automatic t_accum_idle;
    mac(16'h1234, 16'h0F00);
    mac(16'hF00D, 16'h7FFF);
    mac(16'h0001, 16'hFFFF);
    chk("R4 accumulated sum", acc, e_acc);
    repeat (3) cyc();
    chk("R4 idle hold", acc, e_acc);
  endtask

  task automatic t_clear;
    clr = 1; cyc();
    chk("R5 clear alone", acc, 0);
    mac(16'h0100, 16'h0100);
    clr = 1; op_a = 16'h7FFF; op_b = 16'h0003; mac_en = 1; cyc();
    chk("R5 clear with mac", acc, q31(16'h7FFF, 16'h0003));
  endtask

  task automatic t_load;
    ld = 1; ld_val = 36'hA_5555_0001; clr = 1; mac_en = 1; op_a = 16'h4000; op_b = 16'h4000; cyc();
    chk("R6 load overrides", acc, 36'hA_5555_0001);
  endtask

  task automatic t_overflow;
    ovf_clr = 1; cyc();
    ld = 1; ld_val = 36'h7_FFFF_FFFF; cyc();
    chk("R7 no overflow on load", ovf, 0);
    op_a = 16'h4000; op_b = 16'h4000; mac_en = 1; cyc();
    chk("R7 flag set", ovf, 1);
    chk("R7 wrapped sum", acc, 36'h8_1FFF_FFFF);
    ld = 1; ld_val = '0; cyc();
    mac(16'h0010, 16'h0010);
    chk("R7 sticky", ovf, 1);
    ovf_clr = 1; cyc();
    chk("R7 cleared", ovf, 0);
    ld = 1; ld_val = 36'h8_0000_0000; cyc();
    ovf_clr = 1; op_a = 16'hC000; op_b = 16'h4000; mac_en = 1; cyc();
    chk("R7 set wins over clear", ovf, 1);
    ovf_clr = 1; cyc();
  endtask

  task automatic t_pointers;
    logic [15:0] ec, es;
    size_mask = 8'h07; coef_base = 16'h1200; samp_base = 16'h34F5; ptr_ld = 1; cyc();
    chk("R9 coef load", coef_ptr, 16'h1200); chk("R9 samp load", samp_ptr, 16'h34F5);
    ec = 16'h1200; es = 16'h34F5;
    for (int i = 0; i < 10; i++) begin
      op_a = 0; op_b = 0; mac_en = 1; cyc();
      ec = nxt(ec, 8'h07); es = nxt(es, 8'h07);
    end
    chk("R8 coef step", coef_ptr, ec); chk("R8 samp wrap", samp_ptr, es);
    chk("R8 samp wrap value", samp_ptr, 16'h34F7);
    coef_base = 16'h0055; samp_base = 16'h0AA0; ptr_ld = 1; mac_en = 1; cyc();
    chk("R9 load beats step", coef_ptr, 16'h0055);
  endtask

  task automatic t_sizes;
    size_mask = 8'h01; coef_base = 16'hABCD; samp_base = 16'h0000; ptr_ld = 1; cyc();
    mac_en = 1; cyc();
    chk("R10 size 2 wrap", coef_ptr, 16'hABCC);
    size_mask = 8'hFF; coef_base = 16'h12FF; ptr_ld = 1; cyc();
    mac_en = 1; cyc();
    chk("R10 size 256 wrap", coef_ptr, 16'h1200);
    mac_en = 1; cyc();
    chk("R10 size 256 step", coef_ptr, 16'h1201);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset(); t_products(); t_minmin(); t_accum_idle(); t_clear();
        t_load(); t_overflow(); t_pointers(); t_sizes();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule